// File: doc/BRIEF.md
# Time-Slot Shared Memory Arbiter

Eight requesters share one single-port word memory through a fixed rotating schedule. The schedule has sixteen clock cycles. Each requester owns two consecutive cycles of it, and the owners come round in index order. A requester may use memory only in the first cycle of its own pair. If it has nothing ready at that moment, the memory stays idle for that pair. No other requester can take the unused time. Because of this, the latency each requester sees depends only on its own index and on the schedule position at which its request was accepted. It never depends on what the other requesters are doing.

Each requester has a valid/ready request channel that carries a write flag, a word address and write data. A request is taken on a cycle where both valid and ready are high. Ready then stays low until that requester's completion cycle, so a held request is the only back-pressure. While ready is low, valid is ignored. After acceptance, a fixed lead-in of LEAD cycles (default 4) models ordinary execution before the request can meet its window. The window cycle is followed by one memory cycle and then a one-cycle completion pulse. The completion channel has no back-pressure: the pulse and the shared read data are valid in that single cycle only.

Top module: `timeslot_hub`

## Requirements
- R1: While reset is applied and in the first cycle after its release, `slot_now` is 0, every `req_ready` bit is 1 and every `rsp_done` bit is 0.
- R2: Let n count the clock edges since reset release. `slot_now` equals (n mod 16)/2. Each slot value is held for two cycles, and the values run 0 to 7 and wrap to 0, whatever the request traffic.
- R3: A request is taken when `req_valid[i]` and `req_ready[i]` are both 1. From the next cycle `req_ready[i]` is 0 until the cycle of `rsp_done[i]`. Any valid, write flag, address or data presented while ready is 0 is ignored: it produces no completion and no memory change.
- R4: For a request from core i taken in a cycle at schedule position c = n mod 16, `rsp_done[i]` is high exactly D cycles later. D = LEAD + 2 + ((2i − c − LEAD) mod 16). With LEAD = 4, the span from acceptance to completion, counting both ends, is 7 to 22 cycles.
- R5: The latency of R4 holds unchanged when all cores request in the same cycle. An idle slot is never given to another core.
- R6: `rsp_done` is never high for more than one core at a time. Each pulse lasts exactly one cycle.
- R7: A read (write flag 0) returns on `rsp_rdata` the word last written at that address. A write (write flag 1) stores the write data and returns the word's previous content.
- R8: A word written by core k is returned to a read by core k+1 that is served in the very next slot.
- R9: A core that issues a new request exactly 10 cycles after its completion pulse gets the minimum latency D = LEAD + 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NCORE | Request valid, one bit per core |
| req_ready | output | NCORE | High when that core's request register is empty |
| req_write | input | NCORE | 1 = write, 0 = read, one bit per core |
| req_addr | input | NCORE*AW | Word address, core i in bits [i*AW +: AW] |
| req_wdata | input | NCORE*DW | Write data, core i in bits [i*DW +: DW] |
| rsp_done | output | NCORE | One-cycle completion pulse for that core |
| rsp_rdata | output | DW | Read data, valid in the `rsp_done` cycle |
| slot_now | output | log2(NCORE) | Index of the core owning the current slot |

## Verification
When the bench posts a request, it records the schedule position of the acceptance cycle. From that position it computes the cycle in which the completion must appear, using the formula of R4. The scoreboard monitor samples on the falling edge and requires each pulse in exactly that cycle: one cycle early or late is a failure. Ready is checked one cycle after acceptance. Read data is compared in the pulse cycle against a memory model that is updated in completion order, because completion order is the order in which memory is accessed. This covers the next-slot visibility of R8 and the previous-content return of writes.

// File: rtl/hub_pkg.sv
package hub_pkg;
  typedef enum logic {
    OP_RD = 1'b0,
    OP_WR = 1'b1
  } op_e;
endpackage

// File: rtl/hub_slot_timer.sv
// Free-running slot schedule: phase toggles every clock, slot advances
// on the second clock of each pair.
module hub_slot_timer #(
  parameter int NCORE = 8,
  localparam int SW = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] slot,
  output logic          phase
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot  <= '0;
      phase <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        if (slot == SW'(NCORE - 1)) slot <= '0;
        else                        slot <= slot + 1'b1;
      end
    end
  end
endmodule

// File: rtl/hub_core_port.sv
// One-entry request holder with a lead-in counter (LEAD must be >= 1).
module hub_core_port
  import hub_pkg::*;
#(
  parameter int AW   = 10,
  parameter int DW   = 32,
  parameter int LEAD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_write,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_wdata,
  input  logic          retire,
  output logic          in_ready,
  output logic          eligible,
  output op_e           held_op,
  output logic [AW-1:0] held_addr,
  output logic [DW-1:0] held_wdata
);
  localparam int LW = $clog2(LEAD + 1);

  logic          pend;
  logic [LW-1:0] lead;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      lead       <= '0;
      held_op    <= OP_RD;
      held_addr  <= '0;
      held_wdata <= '0;
    end else if (retire) begin
      pend <= 1'b0;
    end else if (in_valid && !pend) begin
      pend       <= 1'b1;
      lead       <= LW'(LEAD - 1);
      held_op    <= in_write ? OP_WR : OP_RD;
      held_addr  <= in_addr;
      held_wdata <= in_wdata;
    end else if (pend && (lead != '0)) begin
      lead <= lead - 1'b1;
    end
  end

  assign in_ready = !pend;
  assign eligible = pend && (lead == '0);
endmodule

// File: rtl/hub_mem_stage.sv
// Window cycle registers the chosen op; the next cycle touches memory;
// the cycle after carries the completion pulse and read data.
module hub_mem_stage
  import hub_pkg::*;
#(
  parameter int NCORE = 8,
  parameter int AW    = 10,
  parameter int DW    = 32,
  localparam int SW   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [SW-1:0]    fire_core,
  input  op_e              fire_op,
  input  logic [AW-1:0]    fire_addr,
  input  logic [DW-1:0]    fire_wdata,
  output logic [NCORE-1:0] retire,
  output logic [NCORE-1:0] done,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic          s1_v;
  logic [SW-1:0] s1_core;
  op_e           s1_op;
  logic [AW-1:0] s1_addr;
  logic [DW-1:0] s1_wdata;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_core  <= '0;
      s1_op    <= OP_RD;
      s1_addr  <= '0;
      s1_wdata <= '0;
    end else begin
      s1_v <= fire;
      if (fire) begin
        s1_core  <= fire_core;
        s1_op    <= fire_op;
        s1_addr  <= fire_addr;
        s1_wdata <= fire_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (s1_v && (s1_op == OP_WR)) mem[s1_addr] <= s1_wdata;
  end

  assign retire = s1_v ? (NCORE'(1) << s1_core) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done  <= '0;
      rdata <= '0;
    end else begin
      done <= retire;
      if (s1_v) rdata <= mem[s1_addr];
    end
  end
endmodule

// File: rtl/timeslot_hub.sv
module timeslot_hub
  import hub_pkg::*;
#(
  parameter int NCORE = 8,
  parameter int AW    = 10,
  parameter int DW    = 32,
  parameter int LEAD  = 4,
  localparam int SW   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCORE-1:0]    req_valid,
  output logic [NCORE-1:0]    req_ready,
  input  logic [NCORE-1:0]    req_write,
  input  logic [NCORE*AW-1:0] req_addr,
  input  logic [NCORE*DW-1:0] req_wdata,
  output logic [NCORE-1:0]    rsp_done,
  output logic [DW-1:0]       rsp_rdata,
  output logic [SW-1:0]       slot_now
);
  logic             phase;
  logic [NCORE-1:0] elig;
  logic [NCORE-1:0] retire;
  op_e              h_op    [NCORE];
  logic [AW-1:0]    h_addr  [NCORE];
  logic [DW-1:0]    h_wdata [NCORE];
  logic             fire;

  hub_slot_timer #(.NCORE(NCORE)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .slot  (slot_now),
    .phase (phase)
  );

  for (genvar i = 0; i < NCORE; i++) begin : g_port
    hub_core_port #(.AW(AW), .DW(DW), .LEAD(LEAD)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (req_valid[i]),
      .in_write   (req_write[i]),
      .in_addr    (req_addr[i*AW +: AW]),
      .in_wdata   (req_wdata[i*DW +: DW]),
      .retire     (retire[i]),
      .in_ready   (req_ready[i]),
      .eligible   (elig[i]),
      .held_op    (h_op[i]),
      .held_addr  (h_addr[i]),
      .held_wdata (h_wdata[i])
    );
  end

  // Only the owner of the current slot, on the first cycle of the pair.
  assign fire = !phase && elig[slot_now];

  hub_mem_stage #(.NCORE(NCORE), .AW(AW), .DW(DW)) u_mem (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .fire_core  (slot_now),
    .fire_op    (h_op[slot_now]),
    .fire_addr  (h_addr[slot_now]),
    .fire_wdata (h_wdata[slot_now]),
    .retire     (retire),
    .done       (rsp_done),
    .rdata      (rsp_rdata)
  );
endmodule

// File: rtl/hub_chk.sv
module hub_chk #(
  parameter int NCORE = 8,
  localparam int SW   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCORE-1:0] req_valid,
  input logic [NCORE-1:0] req_ready,
  input logic [NCORE-1:0] rsp_done,
  input logic [SW-1:0]    slot_now,
  input logic             phase
);
  // R2
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phase |=> (phase && $stable(slot_now)));

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase |=> (!phase && (slot_now == (($past(slot_now) == SW'(NCORE - 1)) ?
                                       SW'(0) : SW'($past(slot_now) + 1'b1)))));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_done));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rsp_done) |=> (rsp_done == '0));

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    // R3
    take_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_ready[i]) |=> !req_ready[i]);

    // R3
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready[i]) |-> rsp_done[i]);

    // R5
    own_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done[i] |-> (!phase && (slot_now == SW'((i + 1) % NCORE))));
  end
endmodule

bind timeslot_hub hub_chk #(.NCORE(NCORE)) u_hub_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .slot_now  (slot_now),
  .phase     (phase)
);

// File: tb/test_timeslot_hub.sv
`timescale 1ns/1ps
module test_timeslot_hub;
  localparam int NC   = 8;
  localparam int AW   = 10;
  localparam int DW   = 32;
  localparam int LEAD = 4;
  localparam int PER  = 2 * NC;
  localparam int SW   = $clog2(NC);

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NC-1:0]    req_valid;
  logic [NC-1:0]    req_ready;
  logic [NC-1:0]    req_write;
  logic [NC*AW-1:0] req_addr;
  logic [NC*DW-1:0] req_wdata;
  logic [NC-1:0]    rsp_done;
  logic [DW-1:0]    rsp_rdata;
  logic [SW-1:0]    slot_now;

  always #4 clk = ~clk;

  timeslot_hub #(.NCORE(NC), .AW(AW), .DW(DW), .LEAD(LEAD)) i_timeslot_hub (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .slot_now(slot_now)
  );

  int cyc;
  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  typedef struct {
    int          core;
    bit          we;
    int          addr;
    logic [DW-1:0] wd;
    int          due;
    string       tag;
  } item_t;

  item_t         sbq[$];
  logic [DW-1:0] model [1 << AW];
  bit            known [1 << AW];
  int            checks = 0;
  int            errors = 0;
  bit            running = 1'b0;
  bit            finished = 1'b0;
  logic [NC-1:0] prev_done = '0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int due_of(int core, int c);
    int w;
    w = (2 * core - c - LEAD + 4 * PER) % PER;
    return LEAD + 2 + w;
  endfunction

  task automatic post(int core, bit we, int addr, logic [DW-1:0] wd,
                      string tag, int fixed = -1);
    item_t it;
    chk(req_ready[core] == 1'b1, "R3", "ready before post", req_ready[core], 1);
    req_valid[core] = 1'b1;
    req_write[core] = we;
    req_addr[core*AW +: AW]  = AW'(addr);
    req_wdata[core*DW +: DW] = wd;
    it.core = core; it.we = we; it.addr = addr; it.wd = wd; it.tag = tag;
    it.due  = cyc + ((fixed >= 0) ? fixed : due_of(core, cyc % PER));
    sbq.push_back(it);
  endtask

  task automatic step(logic [NC-1:0] m);
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NC; i++)
      if (m[i]) chk(req_ready[i] == 1'b0, "R3", "ready after accept", req_ready[i], 0);
    req_valid = req_valid & ~m;
  endtask

  task automatic wait_idle(int core);
    while (!req_ready[core]) @(negedge clk);
  endtask

  task automatic align(int off);
    while ((cyc % PER) != off) @(negedge clk);
  endtask

  task automatic drain();
    while (sbq.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && running) begin
      if ($countones(rsp_done) > 1)
        chk(1'b0, "R6", "done bits at once", $countones(rsp_done), 1);
      if ((prev_done & rsp_done) != '0)
        chk(1'b0, "R6", "done longer than one cycle", rsp_done, 0);
      for (int i = 0; i < NC; i++) begin
        if (rsp_done[i]) begin
          int idx;
          idx = -1;
          for (int k = 0; k < sbq.size(); k++)
            if (idx < 0 && sbq[k].core == i) idx = k;
          if (idx < 0) begin
            chk(1'b0, "R3", "unexpected done for core", i, -1);
          end else begin
            item_t it;
            it = sbq[idx];
            sbq.delete(idx);
            chk(cyc == it.due, it.tag, "done cycle", cyc, it.due);
            if (known[it.addr])
              chk(rsp_rdata == model[it.addr], (it.tag == "R4") ? "R7" : it.tag,
                  "rdata", rsp_rdata, model[it.addr]);
            if (it.we) begin
              model[it.addr] = it.wd;
              known[it.addr] = 1'b1;
            end
          end
        end
      end
      prev_done = rsp_done;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "R4", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cores[3];
    cores = '{0, 3, 7};
    rst_n = 1'b0;
    req_valid = '0; req_write = '0; req_addr = '0; req_wdata = '0;
    repeat (5) @(negedge clk);
    chk(slot_now == 0, "R1", "slot in reset", slot_now, 0);
    chk(req_ready == '1, "R1", "ready in reset", req_ready, 8'hFF);
    chk(rsp_done == '0, "R1", "done in reset", rsp_done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(slot_now == 0, "R1", "slot after reset", slot_now, 0);
    chk(req_ready == '1, "R1", "ready after reset", req_ready, 8'hFF);
    running = 1'b1;

    // R2: schedule rotation without traffic
    repeat (34) begin
      chk(slot_now == SW'((cyc % PER) / 2), "R2", "slot index", slot_now, (cyc % PER) / 2);
      @(negedge clk);
    end

    // R4: every schedule offset for three cores (writes to fresh words)
    foreach (cores[j]) begin
      for (int off = 0; off < PER; off++) begin
        wait_idle(cores[j]);
        align(off);
        post(cores[j], 1'b1, cores[j] * 16 + off, 32'hA000_0000 + cores[j] * 256 + off, "R4");
        step(NC'(1) << cores[j]);
      end
    end
    drain();

    // R2: rotation unchanged after traffic
    repeat (4) begin
      chk(slot_now == SW'((cyc % PER) / 2), "R2", "slot index after traffic", slot_now, (cyc % PER) / 2);
      @(negedge clk);
    end

    // R7: reads and write-returns-old
    foreach (cores[j]) begin
      wait_idle(5);
      post(5, 1'b0, 48 + j * 5, '0, "R7");
      step(NC'(1) << 5);
    end
    wait_idle(1);
    post(1, 1'b1, 48, 32'h1234_5678, "R7");
    step(NC'(1) << 1);
    drain();

    // R5: all cores at once, two offsets
    for (int r = 0; r < 2; r++) begin
      align(r == 0 ? 3 : 9);
      for (int i = 0; i < NC; i++) post(i, 1'b0, 112 + i, '0, "R5");
      step('1);
      drain();
    end

    // R8: write by core 2 then read by core 3 in the next slot
    align(0);
    post(2, 1'b1, 500, 32'hC0FF_EE01, "R8");
    post(3, 1'b0, 500, '0, "R8");
    step(NC'(12));
    drain();

    // R9: re-request 10 cycles after completion hits the next window
    align(5);
    post(6, 1'b0, 48, '0, "R4");
    step(NC'(1) << 6);
    repeat (3) begin
      wait_idle(6);
      repeat (10) @(negedge clk);
      post(6, 1'b0, 48, '0, "R9", LEAD + 2);
      step(NC'(1) << 6);
    end
    drain();

    // R3: valid while pending is ignored
    wait_idle(4);
    post(4, 1'b0, 48, '0, "R3");
    step(NC'(1) << 4);
    req_valid[4] = 1'b1;
    req_write[4] = 1'b1;
    req_addr[4*AW +: AW]  = AW'(49);
    req_wdata[4*DW +: DW] = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    req_valid[4] = 1'b0;
    drain();
    repeat (20) @(negedge clk);
    post(4, 1'b0, 49, '0, "R3");
    step(NC'(1) << 4);
    drain();
    chk(known[49] == 1'b1, "R3", "word 49 keeps first write", known[49], 1);

    chk(sbq.size() == 0, "R6", "outstanding items", sbq.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule